// File: doc/BRIEF.md
# HDLC Transmit Command Controller

This block is the control state machine in front of a bit-level HDLC line encoder whose frames come from a ring of transmit descriptors. When the channel is enabled it looks at the current descriptor's ready bit at a fixed bit-clock interval, or on every cycle when on-demand mode is set. When the descriptor is ready it asks the encoder for frame data until the encoder reports the end of the frame. It then moves its descriptor pointer on and wraps it to zero after the descriptor flagged as last.

Software steers it with three commands. An abrupt stop halts polling at once when the block is idle. During a frame it lets a bounded number of further bits out, flushes the transmit FIFO, sends the 0x7F abort byte and halts with the pointer left where it was. A graceful stop waits for the frame in flight to finish, moves the pointer on, halts and raises a sticky event. A restart is the only way out of either halted state. An encoder error during a frame takes the abort path at once. Between frames the line carries either 0x7E flags or idle ones, chosen by an input.

Top module: `hdlc_tx_ctrl`

## Requirements
- R1: After reset, line_req_o shows fill, bd_ptr_o is 0, gstop_evt_o, fifo_flush_o and poll_o are 0, and the block is polling.
- R2: While polling with chan_en_i high and poll_now_i low, a poll happens on every POLL_TICKS-th bit_en_i pulse (64 by default), and poll_o is high for the one cycle after it. With chan_en_i low no poll happens.
- R3: With poll_now_i high, a poll happens on every clock cycle spent in the polling state.
- R4: A poll that finds bd_ready_i high makes line_req_o equal 2 (frame data) from the next cycle on.
- R5: A frame_end_i pulse during a frame advances bd_ptr_o by one in the next cycle. It wraps to 0 when bd_last_i is high or the pointer is RING_DEPTH-1. The pointer changes at no other time.
- R6: A stop command (cmd_code_i = 1) while polling halts all polling. The line keeps the fill pattern and no flush is made.
- R7: A stop during a frame keeps frame data for ABORT_DELAY more bit_en_i pulses. It then pulses fifo_flush_o for one cycle and drives line_req_o = 3 (abort byte) for 8 bit_en_i pulses, then halts. bd_ptr_o does not change.
- R8: A graceful stop (cmd_code_i = 2) during a frame takes effect when frame_end_i arrives: the pointer advances, the block halts and gstop_evt_o is set. Issued while polling, it halts and sets the event at once.
- R9: gstop_evt_o stays high until an evt_clr_i pulse. A set in the same cycle as a clear wins.
- R10: In either halted state only a restart (cmd_code_i = 3) has effect, and it returns the block to polling with a fresh interval. Stop and graceful stop are ignored there.
- R11: Outside a frame and abort, line_req_o is 1 (flags) when fill_flags_i is high and 0 (idle ones) when it is low.
- R12: A stop that arrives in the same cycle as frame_end_i lets the frame end normally. The pointer advances and the block halts with no flush and no abort byte.
- R13: tx_err_i during a frame starts the flush and abort byte in the next cycle with no extra delay, then halts. The pointer does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_en_i | input | 1 | Channel enable; gates descriptor polling |
| poll_now_i | input | 1 | On-demand mode: poll every cycle |
| fill_flags_i | input | 1 | Fill selection between frames: 1 flags, 0 idle ones |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_code_i | input | 2 | 1 stop, 2 graceful stop, 3 restart, 0 none |
| bit_en_i | input | 1 | One pulse per transmit bit time |
| bd_ready_i | input | 1 | Ready bit of the current descriptor |
| bd_last_i | input | 1 | Current descriptor is the last in the ring |
| frame_end_i | input | 1 | Encoder pulse: frame data finished |
| tx_err_i | input | 1 | Encoder pulse: transmit error during a frame |
| evt_clr_i | input | 1 | Clears the graceful-stop event |
| line_req_o | output | 2 | Encoder request: 0 ones, 1 flags, 2 data, 3 abort |
| fifo_flush_o | output | 1 | One-cycle transmit FIFO flush |
| poll_o | output | 1 | A descriptor poll took place in the previous cycle |
| bd_ptr_o | output | PTR_W | Current descriptor index |
| gstop_evt_o | output | 1 | Sticky graceful-stop event |

## Verification
Two pairs of events can land on the same clock edge. The first is a stop command together with the encoder's end-of-frame pulse. The bench drives both on one edge and expects the pointer to advance and the block to halt with neither flush nor abort byte. The second is an event set from an idle graceful stop together with a clear pulse, where the bench expects the event to remain set. A behavioural model runs alongside the design and judges every output on every cycle, so any slip of a single cycle in these collisions shows up.

// File: rtl/hdlc_tx_pkg.sv
`timescale 1ns/1ps
package hdlc_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE_POLL     = 3'd0,
        ST_SEND          = 3'd1,
        ST_ABORT         = 3'd2,
        ST_STOPPED       = 3'd3,
        ST_GRACE_STOPPED = 3'd4
    } tx_state_e;

    typedef enum logic [1:0] {
        REQ_ONES  = 2'd0,
        REQ_FLAGS = 2'd1,
        REQ_DATA  = 2'd2,
        REQ_ABORT = 2'd3
    } line_req_e;

    localparam logic [1:0] CMD_NOP     = 2'd0;
    localparam logic [1:0] CMD_STOP    = 2'd1;
    localparam logic [1:0] CMD_GSTOP   = 2'd2;
    localparam logic [1:0] CMD_RESTART = 2'd3;

endpackage

// File: rtl/hdlc_tx_poll_timer.sv
`timescale 1ns/1ps
module hdlc_tx_poll_timer #(
    parameter int TICKS = 64,
    localparam int W = $clog2(TICKS)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic tick_i,
    output logic expire_o
);

    logic [W-1:0] cnt_d, cnt_q;

    assign expire_o = tick_i && (cnt_q == W'(TICKS - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (tick_i) begin
            cnt_d = expire_o ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_TIMER_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= W'(TICKS - 1)); // R2

endmodule

// File: rtl/hdlc_tx_bd_ptr.sv
`timescale 1ns/1ps
module hdlc_tx_bd_ptr #(
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv_i,
    input  logic          last_i,
    output logic [PW-1:0] ptr_o
);

    logic [PW-1:0] ptr_d, ptr_q;
    logic          at_end;

    assign at_end = last_i || (ptr_q == PW'(DEPTH - 1));
    assign ptr_o  = ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (adv_i) begin
            ptr_d = at_end ? '0 : ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    AST_PTR_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= PW'(DEPTH - 1)); // R5

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(ptr_q)); // R5

endmodule

// File: rtl/hdlc_tx_evt.sv
`timescale 1ns/1ps
module hdlc_tx_evt (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic evt_o
);

    logic evt_d, evt_q;

    assign evt_o = evt_q;

    always_comb begin
        evt_d = evt_q;
        if (set_i)      evt_d = 1'b1;
        else if (clr_i) evt_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt_q <= 1'b0;
        else        evt_q <= evt_d;
    end

    AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_q && !clr_i) |=> evt_q); // R9

    AST_EVT_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> evt_q); // R9

endmodule

// File: rtl/hdlc_tx_ctrl.sv
`timescale 1ns/1ps
module hdlc_tx_ctrl
    import hdlc_tx_pkg::*;
#(
    parameter int RING_DEPTH  = 8,
    parameter int POLL_TICKS  = 64,
    parameter int ABORT_DELAY = 8,
    parameter int ABORT_BITS  = 8,
    localparam int PTR_W = $clog2(RING_DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chan_en_i,
    input  logic             poll_now_i,
    input  logic             fill_flags_i,
    input  logic             cmd_valid_i,
    input  logic [1:0]       cmd_code_i,
    input  logic             bit_en_i,
    input  logic             bd_ready_i,
    input  logic             bd_last_i,
    input  logic             frame_end_i,
    input  logic             tx_err_i,
    input  logic             evt_clr_i,
    output logic [1:0]       line_req_o,
    output logic             fifo_flush_o,
    output logic             poll_o,
    output logic [PTR_W-1:0] bd_ptr_o,
    output logic             gstop_evt_o
);

    localparam int CNT_MAX = (ABORT_DELAY > ABORT_BITS) ? ABORT_DELAY : ABORT_BITS;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] DELAY_LAST = CNT_W'(ABORT_DELAY - 1);
    localparam logic [CNT_W-1:0] ABORT_LAST = CNT_W'(ABORT_BITS - 1);

    typedef struct packed {
        tx_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic             abort_pend;
        logic             grace_pend;
        logic             flush;
        logic             poll;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic is_stop, is_gstop, is_restart;
    logic timer_expire, timer_clear, poll_hit;
    logic ptr_adv, evt_set;

    assign is_stop    = cmd_valid_i && (cmd_code_i == CMD_STOP);
    assign is_gstop   = cmd_valid_i && (cmd_code_i == CMD_GSTOP);
    assign is_restart = cmd_valid_i && (cmd_code_i == CMD_RESTART);

    assign poll_hit    = (ctl_q.st == ST_IDLE_POLL) && chan_en_i
                         && (poll_now_i || timer_expire);
    assign timer_clear = (ctl_q.st != ST_IDLE_POLL) || !chan_en_i || poll_hit;

    hdlc_tx_poll_timer #(.TICKS(POLL_TICKS)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (timer_clear),
        .tick_i   (bit_en_i),
        .expire_o (timer_expire)
    );

    hdlc_tx_bd_ptr #(.DEPTH(RING_DEPTH)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv_i  (ptr_adv),
        .last_i (bd_last_i),
        .ptr_o  (bd_ptr_o)
    );

    hdlc_tx_evt u_evt (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (evt_set),
        .clr_i (evt_clr_i),
        .evt_o (gstop_evt_o)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.flush = 1'b0;
        ctl_d.poll  = 1'b0;
        ptr_adv     = 1'b0;
        evt_set     = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE_POLL: begin
                if (is_stop) begin
                    ctl_d.st = ST_STOPPED;
                end else if (is_gstop) begin
                    ctl_d.st = ST_GRACE_STOPPED;
                    evt_set  = 1'b1;
                end else if (poll_hit) begin
                    ctl_d.poll = 1'b1;
                    if (bd_ready_i) ctl_d.st = ST_SEND;
                end
            end
            ST_SEND: begin
                if (frame_end_i) begin
                    ptr_adv = 1'b1;
                    if (ctl_q.abort_pend || is_stop) begin
                        ctl_d.st = ST_STOPPED;
                    end else if (ctl_q.grace_pend || is_gstop) begin
                        ctl_d.st = ST_GRACE_STOPPED;
                        evt_set  = 1'b1;
                    end else begin
                        ctl_d.st = ST_IDLE_POLL;
                    end
                    ctl_d.abort_pend = 1'b0;
                    ctl_d.grace_pend = 1'b0;
                    ctl_d.cnt        = '0;
                end else if (tx_err_i) begin
                    ctl_d.st         = ST_ABORT;
                    ctl_d.flush      = 1'b1;
                    ctl_d.cnt        = '0;
                    ctl_d.abort_pend = 1'b0;
                    ctl_d.grace_pend = 1'b0;
                end else if (ctl_q.abort_pend) begin
                    if (bit_en_i) begin
                        if (ctl_q.cnt == DELAY_LAST) begin
                            ctl_d.st         = ST_ABORT;
                            ctl_d.flush      = 1'b1;
                            ctl_d.cnt        = '0;
                            ctl_d.abort_pend = 1'b0;
                            ctl_d.grace_pend = 1'b0;
                        end else begin
                            ctl_d.cnt = ctl_q.cnt + 1'b1;
                        end
                    end
                end else if (is_stop) begin
                    ctl_d.abort_pend = 1'b1;
                    ctl_d.cnt        = '0;
                end else if (is_gstop) begin
                    ctl_d.grace_pend = 1'b1;
                end
            end
            ST_ABORT: begin
                if (bit_en_i) begin
                    if (ctl_q.cnt == ABORT_LAST) begin
                        ctl_d.st  = ST_STOPPED;
                        ctl_d.cnt = '0;
                    end else begin
                        ctl_d.cnt = ctl_q.cnt + 1'b1;
                    end
                end
            end
            ST_STOPPED, ST_GRACE_STOPPED: begin
                if (is_restart) ctl_d.st = ST_IDLE_POLL;
            end
            default: begin
                ctl_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        unique case (ctl_q.st)
            ST_SEND:  line_req_o = REQ_DATA;
            ST_ABORT: line_req_o = REQ_ABORT;
            default:  line_req_o = fill_flags_i ? REQ_FLAGS : REQ_ONES;
        endcase
    end

    assign fifo_flush_o = ctl_q.flush;
    assign poll_o       = ctl_q.poll;

    AST_FLUSH_STARTS_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_flush_o |-> (line_req_o == REQ_ABORT)); // R7

    AST_PTR_ONLY_FROM_SEND: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st != ST_SEND) |=> $stable(bd_ptr_o)); // R5

    AST_POLL_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!chan_en_i || ctl_q.st != ST_IDLE_POLL) |=> !poll_o); // R2

    AST_ABORT_ENDS_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_ABORT && bit_en_i && ctl_q.cnt == ABORT_LAST)
        |=> (ctl_q.st == ST_STOPPED)); // R7

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctl_q.st == ST_STOPPED || ctl_q.st == ST_GRACE_STOPPED) && !is_restart)
        |=> $stable(ctl_q.st)); // R10

    AST_ERR_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_SEND && tx_err_i && !frame_end_i) |=> fifo_flush_o); // R13

endmodule

// File: tb/hdlc_tx_ctrl_bench.sv
`timescale 1ns/1ps
module hdlc_tx_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chan_en = 1'b0, poll_now = 1'b0, fill_flags = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_code = 2'd0;
    logic       bit_en = 1'b0, bd_ready = 1'b0, bd_last = 1'b0;
    logic       frame_end = 1'b0, tx_err = 1'b0, evt_clr = 1'b0;
    logic [1:0] line_req;
    logic       fifo_flush, poll;
    logic [2:0] bd_ptr;
    logic       gstop_evt;

    int tests = 0, fails = 0;
    int bit_every = 1, bit_phase = 0;
    int mon_polls = 0, mon_flush = 0, mon_abort = 0;

    // reference model state: 0 poll, 1 send, 2 abort, 3 stopped, 4 graceful stopped
    int m_st = 0, m_t = 0, m_c = 0, m_ptr = 0;
    bit m_ap = 0, m_gp = 0, m_flush = 0, m_poll = 0, m_evt = 0;

    always #2.5 clk = ~clk;

    hdlc_tx_ctrl u_hdlc_tx_ctrl (
        .clk(clk), .rst_n(rst_n), .chan_en_i(chan_en), .poll_now_i(poll_now),
        .fill_flags_i(fill_flags), .cmd_valid_i(cmd_valid), .cmd_code_i(cmd_code),
        .bit_en_i(bit_en), .bd_ready_i(bd_ready), .bd_last_i(bd_last),
        .frame_end_i(frame_end), .tx_err_i(tx_err), .evt_clr_i(evt_clr),
        .line_req_o(line_req), .fifo_flush_o(fifo_flush), .poll_o(poll),
        .bd_ptr_o(bd_ptr), .gstop_evt_o(gstop_evt)
    );

    task automatic chk(input bit ok, input string tag, input int got, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s got %0d expected %0d", tag, got, exp);
        end
    endtask

    always @(negedge clk) begin
        bit_phase = (bit_phase + 1) % bit_every;
        bit_en = (bit_phase == 0);
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_t = 0; m_c = 0; m_ptr = 0;
            m_ap = 0; m_gp = 0; m_flush = 0; m_poll = 0; m_evt = 0;
        end else begin
            bit stp, gs, rs, pl, adv, setev;
            stp = cmd_valid && cmd_code == 2'd1;
            gs  = cmd_valid && cmd_code == 2'd2;
            rs  = cmd_valid && cmd_code == 2'd3;
            adv = 0; setev = 0; m_flush = 0; m_poll = 0;
            case (m_st)
                0: begin
                    pl = chan_en && (poll_now || (bit_en && m_t == 63));
                    if (pl || !chan_en) m_t = 0;
                    else if (bit_en) m_t = m_t + 1;
                    if (stp) m_st = 3;
                    else if (gs) begin m_st = 4; setev = 1; end
                    else if (pl) begin m_poll = 1; if (bd_ready) m_st = 1; end
                end
                1: begin
                    m_t = 0;
                    if (frame_end) begin
                        adv = 1;
                        if (m_ap || stp) m_st = 3;
                        else if (m_gp || gs) begin m_st = 4; setev = 1; end
                        else m_st = 0;
                        m_ap = 0; m_gp = 0; m_c = 0;
                    end else if (tx_err) begin
                        m_st = 2; m_flush = 1; m_c = 0; m_ap = 0; m_gp = 0;
                    end else if (m_ap) begin
                        if (bit_en) begin
                            if (m_c == 7) begin
                                m_st = 2; m_flush = 1; m_c = 0; m_ap = 0; m_gp = 0;
                            end else m_c = m_c + 1;
                        end
                    end else if (stp) begin
                        m_ap = 1; m_c = 0;
                    end else if (gs) m_gp = 1;
                end
                2: begin
                    m_t = 0;
                    if (bit_en) begin
                        if (m_c == 7) begin m_st = 3; m_c = 0; end
                        else m_c = m_c + 1;
                    end
                end
                default: begin
                    m_t = 0;
                    if (rs) m_st = 0;
                end
            endcase
            if (setev) m_evt = 1;
            else if (evt_clr) m_evt = 0;
            if (adv) m_ptr = (bd_last || m_ptr == 7) ? 0 : m_ptr + 1;
        end
    end

    // cycle-by-cycle comparison against the model
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            int exp_req;
            exp_req = (m_st == 1) ? 2 : (m_st == 2) ? 3 : (fill_flags ? 1 : 0);
            chk(line_req == exp_req, "R4 R11 line request", line_req, exp_req);
            chk(bd_ptr == m_ptr, "R5 pointer", bd_ptr, m_ptr);
            chk(gstop_evt == m_evt, "R9 event", gstop_evt, m_evt);
            chk(fifo_flush == m_flush, "R7 flush", fifo_flush, m_flush);
            chk(poll == m_poll, "R2 poll", poll, m_poll);
            if (poll) mon_polls++;
            if (fifo_flush) mon_flush++;
            if (line_req == 2'd3) mon_abort++;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cmd(input logic [1:0] code);
        cmd_valid = 1'b1; cmd_code = code;
        cyc(1);
        cmd_valid = 1'b0; cmd_code = 2'd0;
    endtask

    task automatic start_frame();
        poll_now = 1'b1; bd_ready = 1'b1;
        while (m_st != 1) cyc(1);
        poll_now = 1'b0; bd_ready = 1'b0;
    endtask

    task automatic end_frame();
        frame_end = 1'b1; cyc(1); frame_end = 1'b0;
    endtask

    initial begin
        int p, s_poll, s_flush, s_abort;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        chk(line_req == 2'd1, "R1 reset fill", line_req, 1);
        chk(bd_ptr == 0, "R1 reset pointer", bd_ptr, 0);
        chk(gstop_evt == 0 && fifo_flush == 0 && poll == 0, "R1 reset flags", gstop_evt, 0);

        s_poll = mon_polls;
        cyc(100);
        chk(mon_polls == s_poll, "R2 no poll when disabled", mon_polls - s_poll, 0);

        chan_en = 1'b1;
        s_poll = mon_polls;
        cyc(200);
        chk(mon_polls - s_poll == 3, "R2 poll interval", mon_polls - s_poll, 3);

        fill_flags = 1'b0; cyc(3);
        chk(line_req == 2'd0, "R11 idle ones", line_req, 0);
        fill_flags = 1'b1; cyc(2);
        chk(line_req == 2'd1, "R11 flags", line_req, 1);

        poll_now = 1'b1; bd_ready = 1'b1;
        cyc(2);
        chk(line_req == 2'd2, "R4 data after ready", line_req, 2);
        poll_now = 1'b0; bd_ready = 1'b0;
        cyc(10);
        end_frame(); cyc(1);
        chk(bd_ptr == 1, "R5 pointer advance", bd_ptr, 1);

        for (int k = 0; k < 3; k++) begin
            s_poll = mon_polls;
            start_frame();
            chk(mon_polls - s_poll <= 2, "R3 on-demand poll", mon_polls - s_poll, 1);
            cyc(5);
            bd_last = (k == 1);
            end_frame();
            bd_last = 1'b0;
        end
        cyc(1);
        chk(bd_ptr == 1, "R5 wrap after last", bd_ptr, 1);

        cmd(2'd1);
        s_poll = mon_polls;
        cyc(150);
        chk(mon_polls == s_poll, "R6 stop halts polling", mon_polls - s_poll, 0);
        chk(line_req == 2'd1 && mon_flush == 0, "R6 fill kept", line_req, 1);
        cmd(2'd2); cmd(2'd1); cyc(70);
        chk(gstop_evt == 0 && mon_polls == s_poll, "R10 ignored when stopped", gstop_evt, 0);
        cmd(2'd3); cyc(70);
        chk(mon_polls > s_poll, "R10 restart resumes", mon_polls - s_poll, 1);

        bit_every = 2;
        start_frame();
        p = bd_ptr; s_flush = mon_flush; s_abort = mon_abort;
        cyc(4);
        cmd(2'd1);
        cyc(10);
        chk(line_req == 2'd2, "R7 data during delay", line_req, 2);
        cyc(50);
        chk(mon_flush - s_flush == 1, "R7 one flush", mon_flush - s_flush, 1);
        chk(mon_abort - s_abort >= 15 && mon_abort - s_abort <= 17, "R7 abort length",
            mon_abort - s_abort, 16);
        chk(bd_ptr == p, "R7 pointer held", bd_ptr, p);
        chk(line_req == 2'd1, "R7 halted fill", line_req, 1);
        cmd(2'd3);
        bit_every = 1;

        start_frame();
        p = bd_ptr;
        cmd(2'd2); cyc(5);
        chk(line_req == 2'd2 && gstop_evt == 0, "R8 frame continues", line_req, 2);
        end_frame(); cyc(1);
        chk(gstop_evt == 1, "R8 event set", gstop_evt, 1);
        chk(bd_ptr == (p + 1) % 8, "R8 pointer advanced", bd_ptr, (p + 1) % 8);
        evt_clr = 1'b1; cyc(1); evt_clr = 1'b0; cyc(1);
        chk(gstop_evt == 0, "R9 clear", gstop_evt, 0);
        cmd(2'd3); cyc(2);
        evt_clr = 1'b1; cmd(2'd2); evt_clr = 1'b0; cyc(1);
        chk(gstop_evt == 1, "R8 R9 idle graceful, set wins", gstop_evt, 1);
        evt_clr = 1'b1; cyc(1); evt_clr = 1'b0;
        cmd(2'd3);

        start_frame();
        p = bd_ptr; s_flush = mon_flush; s_abort = mon_abort; s_poll = mon_polls;
        cyc(3);
        frame_end = 1'b1; cmd(2'd1); frame_end = 1'b0;
        cyc(30);
        chk(bd_ptr == (p + 1) % 8, "R12 pointer advanced", bd_ptr, (p + 1) % 8);
        chk(mon_flush == s_flush && mon_abort == s_abort, "R12 no abort",
            mon_abort - s_abort, 0);
        chk(mon_polls == s_poll, "R12 halted", mon_polls - s_poll, 0);
        cmd(2'd3);

        start_frame();
        p = bd_ptr; s_flush = mon_flush; s_abort = mon_abort;
        cyc(3);
        tx_err = 1'b1; cyc(1); tx_err = 1'b0;
        chk(fifo_flush == 1 && line_req == 2'd3, "R13 immediate abort", line_req, 3);
        cyc(20);
        chk(mon_abort - s_abort == 8, "R13 abort length", mon_abort - s_abort, 8);
        chk(mon_flush - s_flush == 1, "R13 one flush", mon_flush - s_flush, 1);
        chk(bd_ptr == p, "R13 pointer held", bd_ptr, p);
        cmd(2'd3); cyc(5);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        fails++;
        tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule